// File: doc/BRIEF.md
# Shift/Load Register with J-K Serial Entry

This block is a small synchronous register of `WIDTH` stages, four by default. On each rising clock edge it does one of two things, chosen by a mode input. It either captures a parallel data word into all stages at once, or it moves its contents one place from stage 0 toward stage `WIDTH-1`.

In shift mode, stage 0 takes its next value from a J input and an inverted-K input rather than from a plain data bit. With these two inputs, stage 0 can hold, clear, set or toggle itself. Tying the two inputs together makes it a D-type entry.

An asynchronous active-low clear forces every stage to zero at once and keeps it there while the clear is held. All stages appear on a parallel output bus. The last stage also drives a complementary output.

Top module: `jk_shift_load_reg`

## Requirements
- R1: With `shift_en` low, the rising clock edge copies `par_d` into `q` (bit i of `par_d` into stage i).
- R2: With `shift_en` high, each stage i from 1 to WIDTH-1 takes, on the rising edge, the value stage i-1 held before that edge.
- R3: With `shift_en` low, `ser_j` and `ser_kb` have no effect on any stage.
- R4: In shift mode, `ser_j`=0 with `ser_kb`=1 leaves stage 0 unchanged.
- R5: In shift mode, `ser_j`=0 with `ser_kb`=0 makes stage 0 zero.
- R6: In shift mode, `ser_j`=1 with `ser_kb`=1 makes stage 0 one.
- R7: In shift mode, `ser_j`=1 with `ser_kb`=0 inverts stage 0.
- R8: While `clr_n` is low, every stage is 0. This takes effect without waiting for a clock edge, and clock edges during the clear leave all stages at 0.
- R9: `q_last_n` is always the inverse of `q[WIDTH-1]`.
- R10: Apart from the clear, `q` changes only at rising clock edges. Input changes between edges leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_en | input | 1 | 1 = shift toward the last stage, 0 = parallel load |
| ser_j | input | 1 | J serial input to stage 0 |
| ser_kb | input | 1 | Inverted-K serial input to stage 0 |
| par_d | input | WIDTH | Parallel load data |
| q | output | WIDTH | All stage outputs, bit i = stage i |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
Load and shift results pass through one register stage, so they are due at the first rising edge after the inputs are set up. The driver changes inputs on the falling edge and queues the expected word. The monitor compares it 2 ns after the next rising edge, then samples again just before the following edge to confirm nothing moved between edges.

A clear is due immediately. The bench checks for zero 1 ns after pulling `clr_n` low in mid-cycle, then holds the clear across a rising edge so that an all-zero word is also expected at that edge. The complementary output is checked in the same sample as `q`.

// File: rtl/jkreg_pkg.sv
package jkreg_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    JK_CLEAR  = 2'b00,
    JK_HOLD   = 2'b01,
    JK_TOGGLE = 2'b10,
    JK_SET    = 2'b11
  } jk_op_e;
endpackage

// File: rtl/jk_head_stage.sv
module jk_head_stage
  import jkreg_pkg::*;
(
  input  logic cur,
  input  logic ser_j,
  input  logic ser_kb,
  output logic nxt
);
  jk_op_e op;

  always_comb begin
    op = jk_op_e'({ser_j, ser_kb});
    unique case (op)
      JK_HOLD:   nxt = cur;
      JK_CLEAR:  nxt = 1'b0;
      JK_SET:    nxt = 1'b1;
      JK_TOGGLE: nxt = ~cur;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/stage_select.sv
module stage_select
  import jkreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  mode_e            mode,
  input  logic [WIDTH-1:0] par_d,
  input  logic [WIDTH-1:0] cur,
  input  logic             head_nxt,
  output logic [WIDTH-1:0] nxt
);
  // stage 0 takes the J-K result in shift mode
  always_comb begin
    if (mode == MODE_SHIFT) nxt[0] = head_nxt;
    else                    nxt[0] = par_d[0];
  end

  // every later stage takes its neighbour in shift mode
  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    always_comb begin
      if (mode == MODE_SHIFT) nxt[i] = cur[i-1];
      else                    nxt[i] = par_d[i];
    end
  end
endmodule

// File: rtl/jk_shift_load_reg.sv
module jk_shift_load_reg
  import jkreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_en,
  input  logic             ser_j,
  input  logic             ser_kb,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);
  localparam int LAST = WIDTH - 1;

  mode_e            mode;
  logic             head_nxt;
  logic [WIDTH-1:0] stage_nxt;
  logic [WIDTH-1:0] stage_q;

  assign mode = mode_e'(shift_en);

  jk_head_stage u_head (
    .cur    (stage_q[0]),
    .ser_j  (ser_j),
    .ser_kb (ser_kb),
    .nxt    (head_nxt)
  );

  stage_select #(.WIDTH(WIDTH)) u_sel (
    .mode     (mode),
    .par_d    (par_d),
    .cur      (stage_q),
    .head_nxt (head_nxt),
    .nxt      (stage_nxt)
  );

  // the asynchronous clear overrides every clock edge
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= stage_nxt;
  end

  assign q        = stage_q;
  assign q_last_n = ~stage_q[LAST];

  // R1 and R3: the loaded word equals par_d whatever J and K-bar were
  assert_load_capture_R1: assert property (@(posedge clk) disable iff (!clr_n)
    !shift_en |=> q == $past(par_d));

  if (WIDTH > 1) begin : g_chain_chk
    assert_shift_chain_R2: assert property (@(posedge clk) disable iff (!clr_n)
      shift_en |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));
  end

  assert_head_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && !ser_j && ser_kb) |=> q[0] == $past(q[0]));

  assert_head_reset_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && !ser_j && !ser_kb) |=> !q[0]);

  assert_head_set_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && ser_j && ser_kb) |=> q[0]);

  assert_head_toggle_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && ser_j && !ser_kb) |=> q[0] != $past(q[0]));

  assert_clear_zero_R8: assert property (@(posedge clk)
    !clr_n |-> (q == '0 && q_last_n));
endmodule

// File: tb/jk_shift_load_reg_tb_top.sv
module jk_shift_load_reg_tb_top;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0] q;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         shift_en = 1'b0;
  logic         ser_j = 1'b0;
  logic         ser_kb = 1'b1;
  logic [W-1:0] par_d = '0;
  logic [W-1:0] q;
  logic         q_last_n;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];
  logic [W-1:0] model = '0;
  bit done = 0;

  always #4 clk = ~clk;

  jk_shift_load_reg #(.WIDTH(W)) dut_i (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_en (shift_en),
    .ser_j    (ser_j),
    .ser_kb   (ser_kb),
    .par_d    (par_d),
    .q        (q),
    .q_last_n (q_last_n)
  );

  task automatic check(input string tag, input logic [W-1:0] exp_q);
    checks++;
    if (q !== exp_q || q_last_n !== ~exp_q[W-1]) begin
      failures++;
      $display("FAIL %s: q=%b q_last_n=%b expected q=%b q_last_n=%b",
               tag, q, q_last_n, exp_q, ~exp_q[W-1]);
    end
  endtask

  // driver: set inputs on the falling edge, queue the word due at the next rise
  task automatic step(input logic m, input logic j, input logic kb,
                      input logic [W-1:0] d);
    exp_t e;
    @(negedge clk);
    shift_en = m; ser_j = j; ser_kb = kb; par_d = d;
    if (!m) begin
      model = d;
      e.tag = (j || !kb) ? "R1,R3" : "R1";
    end else begin
      logic h;
      if (!j && kb)      begin h = model[0];  e.tag = "R2,R4"; end
      else if (!j && !kb) begin h = 1'b0;     e.tag = "R2,R5"; end
      else if (j && kb)  begin h = 1'b1;      e.tag = "R2,R6"; end
      else               begin h = ~model[0]; e.tag = "R2,R7"; end
      model = {model[W-2:0], h};
    end
    e.q = model;
    sb.push_back(e);
  endtask

  // clear pulled mid-cycle, held across one rising edge, released after it
  task automatic mid_clear();
    exp_t e;
    @(negedge clk);
    #1 clr_n = 1'b0;
    #1 check("R8 immediate", '0);
    shift_en = 1'($urandom); ser_j = 1'($urandom); ser_kb = 1'($urandom);
    par_d = W'($urandom);
    model = '0;
    e.q = '0; e.tag = "R8 edge during clear";
    sb.push_back(e);
    @(posedge clk);
    #3 clr_n = 1'b1;
  endtask

  // monitor: compare 2 ns after each rise, then confirm stability before the next
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      logic [W-1:0] snap;
      e = sb.pop_front();
      #2 check({e.tag, ",R9"}, e.q);
      snap = q;
      #4 if (clr_n) check("R10 stable between edges", snap);
    end
  end

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1 check("R8 reset state", '0);
    @(negedge clk); #1 clr_n = 1'b1;

    // directed patterns
    step(1'b0, 1'b0, 1'b1, 4'b1010);
    step(1'b0, 1'b1, 1'b0, 4'b0101);
    step(1'b0, 1'b1, 1'b1, 4'b0011);
    step(1'b1, 1'b0, 1'b1, 4'b0000);
    step(1'b1, 1'b1, 1'b1, 4'b1111);
    step(1'b1, 1'b0, 1'b0, 4'b1111);
    step(1'b1, 1'b1, 1'b0, 4'b0000);
    step(1'b1, 1'b1, 1'b0, 4'b0000);
    step(1'b0, 1'b0, 1'b0, 4'b1000);
    step(1'b1, 1'b0, 1'b1, 4'b0111);
    mid_clear();
    step(1'b1, 1'b1, 1'b1, 4'b0000);

    // random sequences with occasional clears
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 25) == 0) mid_clear();
      else step(1'($urandom), 1'($urandom), 1'($urandom), W'($urandom));
    end

    repeat (3) @(posedge clk);
    #7;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule